// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the command register that a small CPU uses to program its own flash. Software writes one of a handful of exact command patterns into an 8-bit register. A legal write arms a short window. Within that window a store strobe from the CPU performs the armed operation: it loads one word into the temporary page buffer, clears that buffer, or starts a page erase or a page write. For the configuration-read command, a load strobe within the window reads the fuse or lock bits instead of program memory.

Page erase and page write hand off to the flash array. The block halts the CPU until the array reports completion. Then the block clears the command. When a window passes with no strobe, the command clears by itself. The flash array and the page buffer storage are outside this block. The block only drives their strobes, addresses and data.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and every strobe output and `halt_o` are low. Bits 7..5 of `reg_rdata_o` always read zero.
- R2: In the register, bit 0 is the enable, bit 1 is erase, bit 2 is write, bit 3 is configuration read and bit 4 is buffer clear. A write takes effect only when `reg_wdata_i[4:0]` equals one of five patterns: 00001 (fill), 10001 (clear), 00101 (write), 00011 (erase) or 01001 (configuration read). When it takes effect, the register reads back that pattern. Any other pattern leaves the register unchanged, and bits 7..5 of the write data are ignored.
- R3: A store strobe while fill is armed pulses `buf_we_o` in that cycle. It drives `buf_data_o` = `data_i` and `buf_addr_o` = `zptr_i[PAGE_BYTE_W-1:1]`. The register reads 0x00 from the next cycle on.
- R4: A store strobe while clear is armed pulses `buf_clr_o` in that cycle, with no `buf_we_o`. The register reads 0x00 from the next cycle on.
- R5: A store strobe while erase or write is armed pulses `erase_start_o` or `write_start_o` in that cycle. It drives `page_addr_o` = `zptr_i[Z_W-1:PAGE_BYTE_W]`. From the next cycle, `halt_o` is high and the register keeps its pattern. On the cycle after `flash_done_i` is seen high, `halt_o` falls and the register reads 0x00.
- R6: The cycle after the register write counts as window cycle 1. A store command accepts a strobe in window cycles 1 to 4. With no strobe, the register reads 0x00 from cycle 5, and a strobe in cycle 5 does nothing.
- R7: While configuration read is armed, a load strobe in window cycles 1 to 3 raises `cfg_rd_o` in that cycle. `cfg_sel_o` = `zptr_i[0]` (1 selects fuse bits, 0 selects lock bits). The register then clears. With no load strobe, the register clears from cycle 4, and a load strobe in cycle 4 has no effect.
- R8: While an erase or write is in progress, register writes and strobes are ignored.
- R9: A legal write while a window is open replaces the armed command and restarts the window at cycle 1.
- R10: A strobe with no armed command drives no output. A store strobe during configuration read, and a load strobe during any store command, have no effect, and the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read value |
| store_i | input | 1 | Store-program-memory strobe from the CPU |
| load_i | input | 1 | Load-program-memory strobe from the CPU |
| zptr_i | input | Z_W | CPU byte address pointer |
| data_i | input | DATA_W | CPU data word pair |
| buf_we_o | output | 1 | Page buffer word write |
| buf_addr_o | output | PAGE_BYTE_W-1 | Word address inside the page buffer |
| buf_data_o | output | DATA_W | Word written to the page buffer |
| buf_clr_o | output | 1 | Page buffer clear |
| erase_start_o | output | 1 | Page erase start pulse |
| write_start_o | output | 1 | Page write start pulse |
| page_addr_o | output | Z_W-PAGE_BYTE_W | Page number for erase or write |
| cfg_rd_o | output | 1 | Load returns configuration bits |
| cfg_sel_o | output | 1 | 1 = fuse bits, 0 = lock bits |
| flash_done_i | input | 1 | Flash array finished erase or write |
| halt_o | output | 1 | CPU halt |

## Verification
A wrong command state appears at `reg_rdata_o` on the cycle after the offending edge. It also shows as a strobe pulse that is missing or extra in the same cycle as the CPU strobe. A window counter that is off by one shows only at the window edges: a strobe in cycle 4 (store) or cycle 3 (read) is refused, or a strobe one cycle later is accepted. The bench therefore strobes exactly on those edge cycles. A halt or busy flag that does not release is visible one cycle after `flash_done_i`. A lock that leaks shows as a register readback that changes during a busy operation.

// File: rtl/fspc_pkg.sv
package fspc_pkg;
  typedef enum logic [2:0] {
    CMD_IDLE, CMD_FILL, CMD_CLEAR, CMD_RDCFG, CMD_ERASE, CMD_WRITE
  } cmd_e;

  // register bit image of a command
  function automatic logic [4:0] cmd_bits(cmd_e c);
    case (c)
      CMD_FILL:  return 5'b00001;
      CMD_CLEAR: return 5'b10001;
      CMD_RDCFG: return 5'b01001;
      CMD_ERASE: return 5'b00011;
      CMD_WRITE: return 5'b00101;
      default:   return 5'b00000;
    endcase
  endfunction
endpackage

// File: rtl/fspc_decode.sv
module fspc_decode
  import fspc_pkg::*;
(
  input  logic [4:0] pat_i,
  output logic       legal_o,
  output cmd_e       cmd_o
);
  always_comb begin
    legal_o = 1'b1;
    case (pat_i)
      5'b00001: cmd_o = CMD_FILL;
      5'b10001: cmd_o = CMD_CLEAR;
      5'b01001: cmd_o = CMD_RDCFG;
      5'b00011: cmd_o = CMD_ERASE;
      5'b00101: cmd_o = CMD_WRITE;
      default: begin
        cmd_o   = CMD_IDLE;
        legal_o = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/fspc_window.sv
module fspc_window #(
  parameter int STORE_WIN = 4,
  parameter int READ_WIN  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  input  logic short_i,
  output logic expire_o
);
  localparam int CNT_W = (STORE_WIN > 2) ? $clog2(STORE_WIN) : 1;
  localparam logic [CNT_W-1:0] LIM_ST = CNT_W'(STORE_WIN - 1);
  localparam logic [CNT_W-1:0] LIM_RD = CNT_W'(READ_WIN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim      = short_i ? LIM_RD : LIM_ST;
  assign expire_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (start_i)             cnt_q <= '0;
    else if (run_i && !expire_o)  cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= lim); // R6
  AST_EXPIRE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_o && !start_i) |=> !expire_o); // R7
endmodule

// File: rtl/fspc_issue.sv
module fspc_issue
  import fspc_pkg::*;
#(
  parameter int Z_W         = 16,
  parameter int DATA_W      = 16,
  parameter int PAGE_BYTE_W = 5
) (
  input  logic                       armed_i,
  input  cmd_e                       cmd_i,
  input  logic                       store_i,
  input  logic                       load_i,
  input  logic [Z_W-1:0]             zptr_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic                       service_o,
  output logic                       buf_we_o,
  output logic [PAGE_BYTE_W-2:0]     buf_addr_o,
  output logic [DATA_W-1:0]          buf_data_o,
  output logic                       buf_clr_o,
  output logic                       erase_start_o,
  output logic                       write_start_o,
  output logic [Z_W-PAGE_BYTE_W-1:0] page_addr_o,
  output logic                       cfg_rd_o,
  output logic                       cfg_sel_o
);
  logic st_go;
  assign st_go = armed_i && store_i;

  assign buf_we_o      = st_go && (cmd_i == CMD_FILL);
  assign buf_clr_o     = st_go && (cmd_i == CMD_CLEAR);
  assign erase_start_o = st_go && (cmd_i == CMD_ERASE);
  assign write_start_o = st_go && (cmd_i == CMD_WRITE);
  assign cfg_rd_o      = armed_i && load_i && (cmd_i == CMD_RDCFG);
  assign cfg_sel_o     = cfg_rd_o && zptr_i[0];
  assign service_o     = buf_we_o || buf_clr_o || erase_start_o ||
                         write_start_o || cfg_rd_o;

  // low Z bit selects a byte within the word: dropped
  assign buf_addr_o  = zptr_i[PAGE_BYTE_W-1:1];
  assign buf_data_o  = data_i;
  assign page_addr_o = zptr_i[Z_W-1:PAGE_BYTE_W];
endmodule

// File: rtl/flash_selfprog_ctrl.sv
module flash_selfprog_ctrl
  import fspc_pkg::*;
#(
  parameter int Z_W         = 16,
  parameter int DATA_W      = 16,
  parameter int PAGE_BYTE_W = 5,
  parameter int STORE_WIN   = 4,
  parameter int READ_WIN    = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       reg_we_i,
  input  logic [7:0]                 reg_wdata_i,
  output logic [7:0]                 reg_rdata_o,
  input  logic                       store_i,
  input  logic                       load_i,
  input  logic [Z_W-1:0]             zptr_i,
  input  logic [DATA_W-1:0]          data_i,
  output logic                       buf_we_o,
  output logic [PAGE_BYTE_W-2:0]     buf_addr_o,
  output logic [DATA_W-1:0]          buf_data_o,
  output logic                       buf_clr_o,
  output logic                       erase_start_o,
  output logic                       write_start_o,
  output logic [Z_W-PAGE_BYTE_W-1:0] page_addr_o,
  output logic                       cfg_rd_o,
  output logic                       cfg_sel_o,
  input  logic                       flash_done_i,
  output logic                       halt_o
);
  cmd_e cmd_q, dec_cmd;
  logic busy_q, legal, armed, service, expire, take_wr;

  fspc_decode u_dec (
    .pat_i   (reg_wdata_i[4:0]),
    .legal_o (legal),
    .cmd_o   (dec_cmd)
  );

  assign armed   = (cmd_q != CMD_IDLE) && !busy_q;
  assign take_wr = !busy_q && reg_we_i && legal;

  fspc_window #(.STORE_WIN(STORE_WIN), .READ_WIN(READ_WIN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (take_wr),
    .run_i    (armed),
    .short_i  (cmd_q == CMD_RDCFG),
    .expire_o (expire)
  );

  fspc_issue #(.Z_W(Z_W), .DATA_W(DATA_W), .PAGE_BYTE_W(PAGE_BYTE_W)) u_iss (
    .armed_i       (armed),
    .cmd_i         (cmd_q),
    .store_i       (store_i),
    .load_i        (load_i),
    .zptr_i        (zptr_i),
    .data_i        (data_i),
    .service_o     (service),
    .buf_we_o      (buf_we_o),
    .buf_addr_o    (buf_addr_o),
    .buf_data_o    (buf_data_o),
    .buf_clr_o     (buf_clr_o),
    .erase_start_o (erase_start_o),
    .write_start_o (write_start_o),
    .page_addr_o   (page_addr_o),
    .cfg_rd_o      (cfg_rd_o),
    .cfg_sel_o     (cfg_sel_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_IDLE;
      busy_q <= 1'b0;
    end else if (busy_q) begin
      if (flash_done_i) begin
        busy_q <= 1'b0;
        cmd_q  <= CMD_IDLE;
      end
    end else if (take_wr) begin
      cmd_q <= dec_cmd;
    end else if (service) begin
      if (erase_start_o || write_start_o) busy_q <= 1'b1;
      else                                cmd_q  <= CMD_IDLE;
    end else if (expire) begin
      cmd_q <= CMD_IDLE;
    end
  end

  assign reg_rdata_o = {3'b000, cmd_bits(cmd_q)};
  assign halt_o      = busy_q;

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[7:5] == 3'b000); // R1
  AST_BAD_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && reg_we_i && !legal && !store_i && !load_i && !expire)
      |=> $stable(reg_rdata_o)); // R2
  AST_START_HALTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erase_start_o || write_start_o) |=> halt_o); // R5
  AST_HALT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !flash_done_i) |=> halt_o); // R5
  AST_BUSY_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !flash_done_i) |=> $stable(reg_rdata_o)); // R8
  AST_ONE_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({buf_we_o, buf_clr_o, erase_start_o, write_start_o, cfg_rd_o})); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_rdata_o[0] || halt_o) |->
      !(buf_we_o || buf_clr_o || erase_start_o || write_start_o || cfg_rd_o)); // R10
endmodule

// File: tb/flash_selfprog_ctrl_test.sv
`timescale 1ns/1ps
module flash_selfprog_ctrl_test;
  localparam int Z_W = 16, DATA_W = 16, PBW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, store = 1'b0, load = 1'b0, done = 1'b0;
  logic [7:0] wdata = '0;
  logic [Z_W-1:0] zptr = '0;
  logic [DATA_W-1:0] data = '0;
  logic [7:0] rdata;
  logic buf_we, buf_clr, er_st, wr_st, cfg_rd, cfg_sel, halt;
  logic [PBW-2:0] buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic [Z_W-PBW-1:0] page_addr;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  flash_selfprog_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .store_i(store), .load_i(load), .zptr_i(zptr),
    .data_i(data), .buf_we_o(buf_we), .buf_addr_o(buf_addr),
    .buf_data_o(buf_data), .buf_clr_o(buf_clr), .erase_start_o(er_st),
    .write_start_o(wr_st), .page_addr_o(page_addr), .cfg_rd_o(cfg_rd),
    .cfg_sel_o(cfg_sel), .flash_done_i(done), .halt_o(halt)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // leaves caller at negedge of window cycle 1
  task automatic wr(logic [7:0] v);
    @(negedge clk);
    reg_we = 1'b1; wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [4:0] acts();
    return {buf_we, buf_clr, er_st, wr_st, cfg_rd};
  endfunction

  typedef struct packed { logic [7:0] wd; logic [7:0] exp; } vec_t;
  localparam vec_t VECS [10] = '{
    '{8'h01, 8'h01}, '{8'h11, 8'h11}, '{8'h09, 8'h09}, '{8'h03, 8'h03},
    '{8'h05, 8'h05}, '{8'hF1, 8'h11}, '{8'h07, 8'h00}, '{8'h10, 8'h00},
    '{8'h19, 8'h00}, '{8'h1F, 8'h00}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 reset rdata", rdata, 8'h00);
    chk("R1 reset outputs", {acts(), halt}, 6'b0);
    rst_n = 1'b1;
    step(1);

    // R2: pattern table, each left to expire
    foreach (VECS[i]) begin
      wr(VECS[i].wd);
      chk($sformatf("R2 pattern %h", VECS[i].wd), rdata, VECS[i].exp);
      step(4);
      chk("R6 expired", rdata, 8'h00);
    end

    // R3 fill, strobe in cycle 2
    wr(8'h01); step(1);
    zptr = 16'h1236; data = 16'hBEEF; store = 1'b1; #1;
    chk("R3 buf_we", acts(), 5'b10000);
    chk("R3 buf_addr", buf_addr, 4'hB);
    chk("R3 buf_data", buf_data, 16'hBEEF);
    step(1); store = 1'b0; #1;
    chk("R3 cleared", rdata, 8'h00);

    // R4 clear
    wr(8'h11); store = 1'b1; #1;
    chk("R4 buf_clr", acts(), 5'b01000);
    step(1); store = 1'b0; #1;
    chk("R4 cleared", rdata, 8'h00);

    // R5 erase at window cycle 4 (R6 edge)
    wr(8'h03); step(3);
    zptr = 16'hABCD; store = 1'b1; #1;
    chk("R6 cycle4 erase", acts(), 5'b00100);
    chk("R5 page_addr", page_addr, 11'h55E);
    step(1); store = 1'b0; #1;
    chk("R5 halt", halt, 1'b1);
    chk("R5 busy rdata", rdata, 8'h03);
    wr(8'h01); #1;
    chk("R8 write ignored", rdata, 8'h03);
    store = 1'b1; #1;
    chk("R8 strobe ignored", acts(), 5'b0);
    step(1); store = 1'b0; done = 1'b1; #1;
    chk("R5 halt until done", halt, 1'b1);
    step(1); done = 1'b0; #1;
    chk("R5 halt released", halt, 1'b0);
    chk("R5 rdata cleared", rdata, 8'h00);

    // R5 page write, cycle 1
    wr(8'h05); zptr = 16'h0040; store = 1'b1; #1;
    chk("R5 write_start", acts(), 5'b00010);
    chk("R5 page_addr wr", page_addr, 11'h002);
    step(1); store = 1'b0; #1;
    chk("R5 write busy", {halt, rdata}, {1'b1, 8'h05});
    step(2); done = 1'b1; step(1); done = 1'b0; #1;
    chk("R5 write done", {halt, rdata}, 9'h000);

    // R6 store in cycle 5 refused
    wr(8'h01); step(4); store = 1'b1; #1;
    chk("R6 cycle5 refused", acts(), 5'b0);
    chk("R6 cycle5 rdata", rdata, 8'h00);
    step(1); store = 1'b0;

    // R7 read cycle 3, fuse select
    wr(8'h09); step(2); zptr = 16'h0001; load = 1'b1; #1;
    chk("R7 cfg_rd cycle3", {cfg_rd, cfg_sel}, 2'b11);
    step(1); load = 1'b0; #1;
    chk("R7 cleared", rdata, 8'h00);
    wr(8'h09); zptr = 16'h0000; load = 1'b1; #1;
    chk("R7 lock select", {cfg_rd, cfg_sel}, 2'b10);
    step(1); load = 1'b0;
    wr(8'h09); step(3); zptr = 16'h0001; load = 1'b1; #1;
    chk("R7 cycle4 refused", {cfg_rd, rdata}, 9'h000);
    step(1); load = 1'b0;

    // R9 rewrite restarts window
    wr(8'h01); step(2);
    wr(8'h03); #1;
    chk("R9 replaced", rdata, 8'h03);
    step(3); zptr = 16'h0020; store = 1'b1; #1;
    chk("R9 restarted window", acts(), 5'b00100);
    step(1); store = 1'b0; done = 1'b1; step(1); done = 1'b0;

    // R10 stray strobes
    store = 1'b1; load = 1'b1; #1;
    chk("R10 idle strobes", acts(), 5'b0);
    step(1); store = 1'b0; load = 1'b0;
    wr(8'h09); store = 1'b1; #1;
    chk("R10 store during read", acts(), 5'b0);
    step(1); store = 1'b0; #1;
    chk("R10 read kept", rdata, 8'h09);
    step(3);
    wr(8'h01); load = 1'b1; #1;
    chk("R10 load during fill", acts(), 5'b0);
    step(1); load = 1'b0; #1;
    chk("R10 fill kept", rdata, 8'h01);
    step(5);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule